// File: doc/BRIEF.md
# Replayable Nine-Bit FIFO Buffer

A single-clock first-in/first-out buffer for 9-bit words, so eight data bits can travel with a parity or control bit. Writes and reads are single-cycle enables sampled on the rising clock edge. Internal ring pointers take the place of any address input. The depth is a parameter, meant to be 256, 512 or 1024 entries. An occupancy counter sits beside the pointers, and the three active-low status flags (empty, full, above-half) are all decoded from it.

A retransmit input, active low, rewinds only the read pointer to the first location. The stored data can then be read again from the start while the write pointer keeps its place. The occupancy is reloaded from the write pointer, so every flag reflects the new distance between the pointers. Replay gives correct data only while fewer than depth words have been written since the last reset. Read data is registered. A one-cycle valid strobe marks each accepted read, and the data holds until the next accepted read.

Top module: `fifo9_replay`

## Requirements
- R1: While `rst_n` is low, both pointers and the occupancy clear. From the edge after reset onward, `empty_n`=0, `full_n`=1, `half_n`=1, `rd_valid`=0 and `rd_data`=0.
- R2: Words come out in the order they were written. An accepted read updates `rd_data` and pulses `rd_valid` high on the following edge. `rd_data` then holds until the next accepted read.
- R3: When the buffer is empty (`empty_n`=0), `rd_en` is ignored: `rd_valid` stays 0 and `rd_data` keeps its value.
- R4: `full_n` goes low once the buffer holds DEPTH words. While it is low, `wr_en` is ignored and no stored word is overwritten.
- R5: `half_n` is low exactly when the occupancy is above DEPTH/2. It falls on the write that passes that mark and rises on the read that brings the occupancy back to DEPTH/2.
- R6: A read and a write in the same cycle, with the buffer neither empty nor full, are both performed and leave the occupancy and all flags unchanged.
- R7: A read and a write in the same cycle on an empty buffer store the write only. On a full buffer, the same pair performs the read only.
- R8: A cycle with `rt_n`=0 returns the read pointer to the first location and leaves the write pointer as it was. `rd_en` and `wr_en` are ignored in that cycle. Following reads replay the data from the first word written after reset.
- R9: After a retransmit, the occupancy equals the number of words written since reset, and the empty, full and half flags are recomputed from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request for this cycle |
| rt_n | input | 1 | Retransmit, active low: rewind the read pointer |
| rd_data | output | WIDTH | Last word read, registered |
| rd_valid | output | 1 | One-cycle pulse per accepted read |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The functions that can land in one cycle are an accepted write and an accepted read. They interact with the boundary guards, and a single occupancy update must absorb both. Directed steps drive both enables together at empty, at full, and at a middle fill. A random phase with a fixed seed then drives them together often. A reference queue in the bench, built from the requirements, judges every cycle's strobe, data and all three flags. The rule that a request present during a retransmit cycle has no effect is provoked with `rd_en` and `wr_en` held high, and is judged by the strobe and by the replayed order that follows.

// File: rtl/fifo9_replay.sv
`timescale 1ns/1ps
module fifo9_replay #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rt_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(HALF);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;

  wire is_empty = (count == '0);
  wire is_full  = (count == FULLC);
  wire wr_ok    = rt_n && wr_en && !is_full;
  wire rd_ok    = rt_n && rd_en && !is_empty;

  assign empty_n = !is_empty;
  assign full_n  = !is_full;
  assign half_n  = (count <= HALFC);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (!rt_n) begin
      rptr     <= '0;
      count    <= {1'b0, wptr};
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_ok) begin
        rptr    <= (rptr == LAST) ? '0 : rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
    end
  end

  // R1
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!empty_n && full_n && half_n && !rd_valid && rd_data == '0));

  // R2
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

  // R3
  assert_empty_read_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_en && rt_n) |=> !rd_valid);

  // R4
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_en && !rd_en && rt_n) |=> !full_n);

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));

  // R5
  assert_half_falls_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_n && rt_n && !wr_en) |=> half_n);

  // R6
  assert_balanced_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n && full_n && wr_en && rd_en && rt_n) |=>
      ($stable(empty_n) && $stable(full_n) && $stable(half_n) && rd_valid));

  // R8
  assert_retransmit_blocks_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> !rd_valid);
endmodule

// File: tb/fifo9_replay_bench.sv
`timescale 1ns/1ps
module fifo9_replay_bench;
  localparam int DEPTH = 256;
  localparam int HALF  = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rt_n = 1'b1;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       rd_valid, empty_n, full_n, half_n;

  always #2.5 clk = ~clk;

  fifo9_replay #(.WIDTH(9), .DEPTH(DEPTH)) u_fifo9_replay (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rt_n(rt_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n));

  int checks = 0, failures = 0;
  bit done = 0;

  logic [8:0] m_mem [DEPTH];
  int m_wp, m_rp, m_cnt, m_total;
  logic [8:0] m_last;
  bit m_valid;

  function automatic bit exp_empty_n(int c); return c != 0; endfunction
  function automatic bit exp_full_n(int c);  return c != DEPTH; endfunction
  function automatic bit exp_half_n(int c);  return c <= HALF; endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs(string tag);
    chk(rd_valid === m_valid, tag, rd_valid, m_valid);
    chk(rd_data === m_last, tag, rd_data, m_last);
    chk(empty_n === exp_empty_n(m_cnt), "R3", empty_n, exp_empty_n(m_cnt));
    chk(full_n === exp_full_n(m_cnt), "R4", full_n, exp_full_n(m_cnt));
    chk(half_n === exp_half_n(m_cnt), "R5", half_n, exp_half_n(m_cnt));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; rt_n = 1;
    @(negedge clk); @(negedge clk);
    m_wp = 0; m_rp = 0; m_cnt = 0; m_total = 0; m_last = '0; m_valid = 0;
    chk(empty_n === 1'b0, "R1", empty_n, 0);
    chk(full_n === 1'b1, "R1", full_n, 1);
    chk(half_n === 1'b1, "R1", half_n, 1);
    chk(rd_valid === 1'b0, "R1", rd_valid, 0);
    chk(rd_data === 9'd0, "R1", rd_data, 0);
    rst_n = 1'b1;
  endtask

  task automatic step(bit w, bit r, bit rt, logic [8:0] d, string tag);
    bit wok, rok;
    wr_en = w; rd_en = r; rt_n = !rt; wr_data = d;
    @(posedge clk);
    if (rt) begin
      m_rp = 0; m_cnt = m_wp; m_valid = 0;
    end else begin
      wok = w && (m_cnt < DEPTH);
      rok = r && (m_cnt > 0);
      m_valid = rok;
      if (rok) begin
        m_last = m_mem[m_rp];
        m_rp = (m_rp + 1) % DEPTH;
      end
      if (wok) begin
        m_mem[m_wp] = d;
        m_wp = (m_wp + 1) % DEPTH;
        m_total++;
      end
      m_cnt = m_cnt + int'(wok) - int'(rok);
    end
    @(negedge clk);
    check_outputs(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    step(0, 1, 0, 9'h000, "R3");
    step(1, 1, 0, 9'h1A5, "R7");
    step(0, 1, 0, 9'h000, "R2");
    chk(rd_data === 9'h1A5, "R7", rd_data, 9'h1A5);

    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 9'(i * 3 + 1), "R2");
    chk(full_n === 1'b0, "R4", full_n, 0);
    chk(half_n === 1'b0, "R5", half_n, 0);
    step(1, 0, 0, 9'h0FF, "R4");
    step(1, 1, 0, 9'h0EE, "R7");
    chk(rd_data === 9'h001, "R7", rd_data, 9'h001);
    while (m_cnt > HALF + 1) step(0, 1, 0, 9'h000, "R2");
    chk(half_n === 1'b0, "R5", half_n, 0);
    step(0, 1, 0, 9'h000, "R5");
    chk(half_n === 1'b1, "R5", half_n, 1);
    for (int i = 0; i < 5; i++) step(1, 1, 0, 9'(9'h100 + i), "R6");
    while (m_cnt > 0) step(0, 1, 0, 9'h000, "R2");
    step(0, 1, 0, 9'h000, "R3");

    do_reset();
    for (int i = 0; i < 10; i++) step(1, 0, 0, 9'(9'h050 + i), "R2");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 9'h000, "R2");
    step(1, 1, 1, 9'h077, "R8");
    chk(rd_valid === 1'b0, "R8", rd_valid, 0);
    for (int i = 0; i < 10; i++) begin
      step(0, 1, 0, 9'h000, "R8");
      chk(rd_data === 9'(9'h050 + i), "R8", rd_data, 9'(9'h050 + i));
    end
    chk(empty_n === 1'b0, "R9", empty_n, 0);

    do_reset();
    for (int i = 0; i < 200; i++) step(1, 0, 0, 9'(i), "R2");
    for (int i = 0; i < 100; i++) step(0, 1, 0, 9'h000, "R2");
    chk(half_n === 1'b1, "R5", half_n, 1);
    step(0, 0, 1, 9'h000, "R9");
    chk(half_n === 1'b0, "R9", half_n, 0);

    do_reset();
    for (int i = 0; i < 4000; i++) begin
      bit w, r, rt;
      int sel;
      sel = int'($urandom % 100);
      w = ($urandom % 100) < 55;
      r = ($urandom % 100) < 50;
      rt = (sel < 2) && (m_total < DEPTH);
      step(w, r, rt, 9'($urandom), rt ? "R8" : ((w && r) ? "R6" : "R2"));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule